// File: doc/BRIEF.md
# Round-Robin Warp Fetch Sequencer

This block is the instruction front end of a small SIMT core. It keeps one program counter for each warp. In every cycle it picks one warp that is allowed to proceed and fetches that warp's next instruction from a small built-in program. The instruction then moves through decode, execute, memory and writeback stages, one cycle per stage. Warps take turns in rotating order. A warp is passed over while it has an unresolved branch in flight, while it waits for a cache miss to be filled, or once it has fetched its return instruction. When no warp can go, an empty slot enters the pipeline.

All warps run the same program. The conditional branch at address 1 depends on the warp's first thread index, compared against a run-time element count. In this way the warps can follow different paths through the same code. Every lane of a warp carries the same instruction. The block exposes the thread index of each lane in execute, so the thread-to-warp partition can be seen at the ports. A completion flag rises after every warp's return instruction has left writeback.

Top module: `wfs_sequencer`

## Requirements
- R1: At most one instruction is fetched per cycle. The fetched warp is the first eligible warp found when searching upward, with wrap-around, from the warp fetched most recently. After reset the search starts so that warp 0 is tried first.
- R2: In a cycle where no warp is eligible, `fe_valid` is 0 and an empty slot moves down the pipeline.
- R3: An instruction fetched in cycle k is in execute in cycle k+2, in memory in cycle k+3 and in writeback in cycle k+4, with the same warp and PC. Each warp's instructions reach writeback in program order.
- R4: If `mem_miss` is 1 in a cycle where the memory stage holds a load (opcode 1), that warp is not fetched from the next cycle onward. It becomes eligible again in the cycle after `fill_valid` is 1 with `fill_warp` naming it.
- R5: The conditional branch (opcode 3) is taken when the warp's first thread index, warp×WARP_SIZE, is less than `n_limit`. When taken, the PC becomes 3; otherwise it advances to 2. The unconditional branch (opcode 4) always goes to 7. After fetching either branch, the warp is not fetched again before the cycle after that branch is in execute.
- R6: The program, by PC, is: 0 ALU (opcode 0), 1 conditional branch, 2 unconditional branch, 3 load, 4 load, 5 ALU, 6 store (opcode 2), 7 return (opcode 5). Every address above 7 also holds a return. `fe_op` shows the opcode of the fetched instruction.
- R7: Once a warp has fetched a return, it is never fetched again until reset.
- R8: `all_done` rises in the cycle after the last warp's return is in writeback. It then stays at 1 until reset.
- R9: In execute, lane l of warp w reports thread index w×WARP_SIZE+l in field l of `ex_lane_tid` (lane 0 in the low bits).
- R10: During reset the execute, memory and writeback stages are empty and `all_done` is 0. The first fetch after reset is warp 0 at PC 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| n_limit | input | NL_W | Element count compared by the conditional branch |
| mem_miss | input | 1 | The load now in the memory stage missed the cache |
| fill_valid | input | 1 | A miss has been filled |
| fill_warp | input | WID_W | Warp whose miss has been filled |
| fe_valid | output | 1 | An instruction is fetched this cycle |
| fe_warp | output | WID_W | Warp being fetched |
| fe_pc | output | PC_W | PC being fetched |
| fe_op | output | 3 | Opcode being fetched |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_warp | output | WID_W | Warp in execute |
| ex_lane_tid | output | WARP_SIZE*TID_W | Thread index of each lane in execute |
| mem_valid | output | 1 | Memory stage holds an instruction |
| mem_warp | output | WID_W | Warp in the memory stage |
| mem_op | output | 3 | Opcode in the memory stage |
| wb_valid | output | 1 | Writeback stage holds an instruction |
| wb_warp | output | WID_W | Warp in writeback |
| wb_pc | output | PC_W | PC in writeback |
| all_done | output | 1 | Every warp has retired its return |

## Verification
The bench records the full fetch trace of every scenario and compares it cycle by cycle. One trace has both warps branching to the load path, one has the warps take different paths, and one has a load miss that is filled later. If the arbiter restarted its search at warp 0, warp 0 would be fetched twice in a row where warp 1 was due. If the branch blocking were missing, the warp would be fetched again from PC 2 before execute resolved the branch. If a pending miss were ignored, warp 0 would appear in the fetch slots while warp 1 runs alone. The cycle in which completion rises, the writeback timing and the lane thread indices are also pinned to exact cycles. A stage counted wrong or a warp index off by one therefore shows up as a mismatch.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

  typedef enum logic [2:0] {
    OP_ALU = 3'd0,
    OP_LD  = 3'd1,
    OP_ST  = 3'd2,
    OP_BRC = 3'd3,
    OP_BRA = 3'd4,
    OP_RET = 3'd5
  } op_e;

  // built-in program shared by all warps
  function automatic op_e prog_op(input int unsigned pc);
    case (pc)
      0: return OP_ALU;
      1: return OP_BRC;
      2: return OP_BRA;
      3: return OP_LD;
      4: return OP_LD;
      5: return OP_ALU;
      6: return OP_ST;
      default: return OP_RET;
    endcase
  endfunction

  function automatic int unsigned prog_tgt(input int unsigned pc);
    case (pc)
      1: return 3;
      2: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_branch(input op_e op);
    return (op == OP_BRC) || (op == OP_BRA);
  endfunction

  function automatic logic branch_taken(input op_e op, input int unsigned first_tid,
                                        input int unsigned limit);
    return (op == OP_BRA) || ((op == OP_BRC) && (first_tid < limit));
  endfunction

  function automatic int unsigned lane_tid(input int unsigned warp, input int unsigned lane,
                                           input int unsigned wsize);
    return warp * wsize + lane;
  endfunction

endpackage

// File: rtl/wfs_rr_arb.sv
module wfs_rr_arb #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  output logic          grant_vld,
  output logic [IW-1:0] grant_idx
);

  logic [IW-1:0] last_q;

  always_comb begin
    grant_vld = 1'b0;
    grant_idx = '0;
    for (int k = 1; k <= N; k++) begin
      int cand;
      cand = (int'(last_q) + k) % N;
      if (!grant_vld && elig[cand]) begin
        grant_vld = 1'b1;
        grant_idx = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_q <= IW'(N - 1);
    else if (grant_vld) last_q <= grant_idx;
  end

  p_grant_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> elig[grant_idx]);

  p_bubble_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |-> grant_vld);

endmodule

// File: rtl/wfs_warp_ctx.sv
module wfs_warp_ctx import wfs_pkg::*; #(
  parameter int PC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  op_e             take_op,
  input  logic            br_done,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_tgt,
  input  logic            miss_set,
  input  logic            fill_clr,
  output logic [PC_W-1:0] pc,
  output logic            eligible
);

  logic pend_q, brw_q, fin_q;

  assign eligible = !pend_q && !brw_q && !fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      pend_q <= 1'b0;
      brw_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      if (take) begin
        pc <= pc + 1'b1;
        if (is_branch(take_op)) brw_q <= 1'b1;
        if (take_op == OP_RET)  fin_q <= 1'b1;
      end
      if (br_done) begin
        brw_q <= 1'b0;
        if (br_taken) pc <= br_tgt;
      end
      if (fill_clr) pend_q <= 1'b0;
      if (miss_set) pend_q <= 1'b1;
    end
  end

  p_branch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brw_q |-> !take);

  p_ret_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> !take);

  p_miss_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !take);

endmodule

// File: rtl/wfs_pipe.sv
module wfs_pipe import wfs_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int WID_W = 1,
  parameter int PC_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [WID_W-1:0] in_w,
  input  logic [PC_W-1:0]  in_pc,
  input  op_e              in_op,
  output logic             st_v  [DEPTH],
  output logic [WID_W-1:0] st_w  [DEPTH],
  output logic [PC_W-1:0]  st_pc [DEPTH],
  output op_e              st_op [DEPTH]
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_stg
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_v[s] <= 1'b0; st_w[s] <= '0; st_pc[s] <= '0; st_op[s] <= OP_ALU;
        end else begin
          st_v[s] <= in_v; st_w[s] <= in_w; st_pc[s] <= in_pc; st_op[s] <= in_op;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_v[s] <= 1'b0; st_w[s] <= '0; st_pc[s] <= '0; st_op[s] <= OP_ALU;
        end else begin
          st_v[s] <= st_v[s-1]; st_w[s] <= st_w[s-1];
          st_pc[s] <= st_pc[s-1]; st_op[s] <= st_op[s-1];
        end
      end

      p_stage_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_v[s-1] |=> (st_v[s] && st_w[s] == $past(st_w[s-1]) && st_pc[s] == $past(st_pc[s-1])));
    end
  end

endmodule

// File: rtl/wfs_sequencer.sv
module wfs_sequencer import wfs_pkg::*; #(
  parameter int NUM_WARPS = 2,
  parameter int WARP_SIZE = 4,
  parameter int PC_W      = 4,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int TID_W    = (NUM_WARPS * WARP_SIZE > 1) ? $clog2(NUM_WARPS * WARP_SIZE) : 1,
  localparam int NL_W     = TID_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NL_W-1:0]            n_limit,
  input  logic                       mem_miss,
  input  logic                       fill_valid,
  input  logic [WID_W-1:0]           fill_warp,
  output logic                       fe_valid,
  output logic [WID_W-1:0]           fe_warp,
  output logic [PC_W-1:0]            fe_pc,
  output logic [2:0]                 fe_op,
  output logic                       ex_valid,
  output logic [WID_W-1:0]           ex_warp,
  output logic [WARP_SIZE*TID_W-1:0] ex_lane_tid,
  output logic                       mem_valid,
  output logic [WID_W-1:0]           mem_warp,
  output logic [2:0]                 mem_op,
  output logic                       wb_valid,
  output logic [WID_W-1:0]           wb_warp,
  output logic [PC_W-1:0]            wb_pc,
  output logic                       all_done
);

  localparam int DEPTH = 4;  // decode, execute, memory, writeback
  localparam int S_EX  = 1;
  localparam int S_MEM = 2;
  localparam int S_WB  = 3;

  logic [NUM_WARPS-1:0] elig;
  logic [NUM_WARPS-1:0] retired_q;
  logic [PC_W-1:0]      pc_q [NUM_WARPS];
  logic                 gvld;
  logic [WID_W-1:0]     gidx;
  op_e                  fop;

  logic             st_v  [DEPTH];
  logic [WID_W-1:0] st_w  [DEPTH];
  logic [PC_W-1:0]  st_pc [DEPTH];
  op_e              st_op [DEPTH];

  // named internal events
  logic            ex_br, ex_taken, mem_miss_evt, wb_ret_evt;
  logic [PC_W-1:0] ex_tgt;

  wfs_rr_arb #(.N(NUM_WARPS), .IW(WID_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .grant_vld(gvld), .grant_idx(gidx)
  );

  assign fop = prog_op(32'(pc_q[gidx]));

  wfs_pipe #(.DEPTH(DEPTH), .WID_W(WID_W), .PC_W(PC_W)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_v(gvld), .in_w(gidx), .in_pc(pc_q[gidx]), .in_op(fop),
    .st_v(st_v), .st_w(st_w), .st_pc(st_pc), .st_op(st_op)
  );

  assign ex_br        = st_v[S_EX] && is_branch(st_op[S_EX]);
  assign ex_taken     = branch_taken(st_op[S_EX], 32'(st_w[S_EX]) * WARP_SIZE, 32'(n_limit));
  assign ex_tgt       = PC_W'(prog_tgt(32'(st_pc[S_EX])));
  assign mem_miss_evt = st_v[S_MEM] && (st_op[S_MEM] == OP_LD) && mem_miss;
  assign wb_ret_evt   = st_v[S_WB] && (st_op[S_WB] == OP_RET);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    wfs_warp_ctx #(.PC_W(PC_W)) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .take(gvld && gidx == WID_W'(w)),
      .take_op(fop),
      .br_done(ex_br && st_w[S_EX] == WID_W'(w)),
      .br_taken(ex_taken),
      .br_tgt(ex_tgt),
      .miss_set(mem_miss_evt && st_w[S_MEM] == WID_W'(w)),
      .fill_clr(fill_valid && fill_warp == WID_W'(w)),
      .pc(pc_q[w]),
      .eligible(elig[w])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) retired_q[w] <= 1'b0;
      else if (wb_ret_evt && st_w[S_WB] == WID_W'(w)) retired_q[w] <= 1'b1;
    end
  end

  for (genvar l = 0; l < WARP_SIZE; l++) begin : g_lane
    assign ex_lane_tid[l*TID_W +: TID_W] = TID_W'(lane_tid(32'(st_w[S_EX]), l, WARP_SIZE));
  end

  assign all_done  = &retired_q;
  assign fe_valid  = gvld;
  assign fe_warp   = gidx;
  assign fe_pc     = pc_q[gidx];
  assign fe_op     = fop;
  assign ex_valid  = st_v[S_EX];
  assign ex_warp   = st_w[S_EX];
  assign mem_valid = st_v[S_MEM];
  assign mem_warp  = st_w[S_MEM];
  assign mem_op    = st_op[S_MEM];
  assign wb_valid  = st_v[S_WB];
  assign wb_warp   = st_w[S_WB];
  assign wb_pc     = st_pc[S_WB];

  p_miss_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_miss_evt |=> !(fe_valid && fe_warp == $past(st_w[S_MEM])));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |=> all_done);

  p_done_needs_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_done) |-> $past(wb_ret_evt));

endmodule

// File: tb/wfs_sequencer_tb.sv
`timescale 1ns/1ps
module wfs_sequencer_tb;
  localparam int NW = 2, WS = 4, PCW = 4, WIDW = 1, TIDW = 3, NLW = 4;

  logic clk = 0, rst_n = 0;
  logic [NLW-1:0] n_limit = '0;
  logic mem_miss = 0, fill_valid = 0;
  logic [WIDW-1:0] fill_warp = '0;
  logic fe_valid, ex_valid, mem_valid, wb_valid, all_done;
  logic [WIDW-1:0] fe_warp, ex_warp, mem_warp, wb_warp;
  logic [PCW-1:0] fe_pc, wb_pc;
  logic [2:0] fe_op, mem_op;
  logic [WS*TIDW-1:0] ex_lane_tid;

  int n_chk = 0, n_err = 0;
  int cap_fe [40], cap_op [40], cap_wb [40], cap_mem [40], cap_done [40], cap_tid [40];

  always #4 clk = ~clk;

  wfs_sequencer #(.NUM_WARPS(NW), .WARP_SIZE(WS), .PC_W(PCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .n_limit(n_limit), .mem_miss(mem_miss),
    .fill_valid(fill_valid), .fill_warp(fill_warp),
    .fe_valid(fe_valid), .fe_warp(fe_warp), .fe_pc(fe_pc), .fe_op(fe_op),
    .ex_valid(ex_valid), .ex_warp(ex_warp), .ex_lane_tid(ex_lane_tid),
    .mem_valid(mem_valid), .mem_warp(mem_warp), .mem_op(mem_op),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_pc(wb_pc), .all_done(all_done)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // trace encoding: warp*16+pc, -1 for an empty fetch slot
  task automatic run(input int nl, input int ncyc, input int miss_c, input int fill_c, input int fill_w);
    n_limit = NLW'(nl); mem_miss = 0; fill_valid = 0; fill_warp = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    // R10: empty stages and no completion while in reset
    chk("R10 ex_valid in reset", int'(ex_valid), 0);
    chk("R10 mem_valid in reset", int'(mem_valid), 0);
    chk("R10 wb_valid in reset", int'(wb_valid), 0);
    chk("R10 all_done in reset", int'(all_done), 0);
    rst_n = 1;
    for (int c = 0; c < ncyc; c++) begin
      #1;
      cap_fe[c]   = fe_valid ? int'(fe_warp) * 16 + int'(fe_pc) : -1;
      cap_op[c]   = int'(fe_op);
      cap_wb[c]   = wb_valid ? int'(wb_warp) * 16 + int'(wb_pc) : -1;
      cap_mem[c]  = mem_valid ? int'(mem_warp) * 16 + int'(mem_op) : -1;
      cap_done[c] = int'(all_done);
      cap_tid[c]  = int'(ex_lane_tid);
      mem_miss   = (c == miss_c);
      fill_valid = (c == fill_c);
      fill_warp  = WIDW'(fill_w);
      @(negedge clk);
    end
    mem_miss = 0; fill_valid = 0;
  endtask

  task automatic test_both_taken();
    int exp_t [16] = '{0, 16, 1, 17, -1, 3, 19, 4, 20, 5, 21, 6, 22, 7, 23, -1};
    run(8, 20, -1, -1, 0);
    chk("R10 first fetch warp0 pc0", cap_fe[0], 0);
    for (int c = 0; c < 16; c++)
      chk(exp_t[c] < 0 ? "R2 empty slot" : "R1 R5 round-robin trace", cap_fe[c], exp_t[c]);
    chk("R6 opcode at pc1", cap_op[2], 3);
    chk("R6 opcode at pc7", cap_op[13], 5);
    chk("R3 writeback of cycle-5 fetch", cap_wb[9], 3);
    chk("R3 writeback of last return", cap_wb[18], 23);
    chk("R9 lane tids warp0", cap_tid[2], (3 << 9) | (2 << 6) | (1 << 3) | 0);
    chk("R9 lane tids warp1", cap_tid[3], (7 << 9) | (6 << 6) | (5 << 3) | 4);
    chk("R8 not done before last retire", cap_done[18], 0);
    chk("R8 done after last retire", cap_done[19], 1);
  endtask

  task automatic test_split_paths();
    int exp_t [13] = '{0, 16, 1, 17, -1, 3, 18, 4, 5, 23, 6, 7, -1};
    run(4, 17, -1, -1, 0);
    for (int c = 0; c < 13; c++)
      chk(exp_t[c] < 0 ? "R2 R7 empty slot" : "R5 divergent trace", cap_fe[c], exp_t[c]);
    chk("R6 unconditional branch opcode", cap_op[6], 4);
    for (int c = 12; c < 17; c++) chk("R7 no fetch after returns", cap_fe[c], -1);
    chk("R3 warp1 return writeback", cap_wb[13], 23);
    chk("R8 not done early", cap_done[15], 0);
    chk("R8 done", cap_done[16], 1);
  endtask

  task automatic test_miss();
    int exp_t [18] = '{0, 16, 1, 17, -1, 3, 19, 4, 20, 21, 22, 23, -1, -1, 5, 6, 7, -1};
    run(8, 18, 8, 13, 0);
    chk("R4 load of warp0 in memory stage", cap_mem[8], 1);
    for (int c = 0; c < 18; c++)
      chk(c >= 9 ? "R4 R7 trace around miss" : "R1 trace before miss", cap_fe[c], exp_t[c]);
  endtask

  initial begin
    #(200000 * 8);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    test_both_taken();
    test_split_paths();
    test_miss();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule